// File: doc/BRIEF.md
# Single-Channel Multi-Mode DMA Controller

This block moves words between system memory and one peripheral, or from one memory region to another, without the processor doing the copying. Software loads a source pointer, a destination pointer, a word count and a control word (direction, bus-holding policy, interrupt enable), and then writes a go command. The controller asks for the shared bus with a request line. It does a transfer cycle only while the arbiter grants the bus. How long it keeps the bus depends on the selected policy. In burst it keeps the bus for the whole job. In cycle-steal it hands the bus back after each word. In block it keeps the bus for a fixed chunk of words. In demand it moves words only while the peripheral asks.

The pointers and the count are live counters. They step as words move, and software writes to them are refused while a job runs. Completion, fault, refused-start and interrupt flags are sticky and are cleared by writing ones to a clear register. A fault ends the job early. A fault is either an address above a configured ceiling or an error response from the bus.

Top module: `dma_ctl`

## Requirements
- R1: Register writes, with reg_sel 0 = source pointer, 1 = destination pointer, 2 = word count and 3 = control, are accepted only while busy is low. The control word has bits [1:0] for direction, bits [3:2] for policy and bit [4] for interrupt enable. Direction: 0 = memory to peripheral, 1 = peripheral to memory, 2 or 3 = memory to memory. Policy: 0 = burst, 1 = cycle-steal, 2 = block, 3 = demand. Writes made while busy is high have no effect.
- R2: bus_valid is high only in a cycle where bus_req and bus_gnt are both high. bus_req rises in the cycle after the go command (reg_sel 4, bit 0) is accepted, except in demand policy.
- R3: In burst policy, bus_req stays high without a break from the first word until the last word, so a job has a single request rising edge.
- R4: In cycle-steal policy, bus_req is low for exactly one cycle after every word that is not the last, so an N-word job has N request rising edges.
- R5: In block policy, BLK_LEN words (default 4) move per request. bus_req then drops for one cycle, so an N-word job has ceil(N/BLK_LEN) request rising edges.
- R6: In demand policy, no word moves in a cycle where per_req is low. If per_req is low in a cycle where the bus is held, bus_req drops in the next cycle. After that, bus_req rises in the cycle after per_req is seen high.
- R7: One cycle after the last word, busy and bus_req are low and done is set. irq is set in the same cycle only when interrupt enable is 1.
- R8: A faulting access sets err, ends the job and drops bus_req in the next cycle. An access faults if its address is above ADDR_LIMIT (default 0xFF), in which case no bus cycle is issued, or if bus_err is high with bus_valid. A fault sets irq when interrupt enable is 1, and done stays clear.
- R9: Each word uses the source pointer for reads and the destination pointer for writes, and each pointer steps by one after it is used. A memory-to-memory word takes a read beat and then a write beat that carries the read data. per_ack pulses once per peripheral word.
- R10: A go command that arrives while busy is high is ignored and sets busy_err.
- R11: If the grant is withdrawn while the bus is held, no word moves. bus_req stays high, bus_addr holds its value, and the job resumes from the same address when the grant returns.
- R12: A go command with a word count of 0 sets done in the next cycle, and bus_req never rises. irq is also set when interrupt enable is 1.
- R13: done, err, busy_err and irq stay set until software writes reg_sel 5 with bit 0, 1, 2 or 3 set, respectively. If a flag is set and cleared in the same cycle, it ends up set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_sel | input | 3 | Register select |
| reg_wdata | input | max(AW,CW) | Register write data |
| bus_req | output | 1 | Bus ownership request |
| bus_gnt | input | 1 | Bus grant from arbiter |
| bus_valid | output | 1 | Bus transfer cycle this clock |
| bus_we | output | 1 | Transfer is a memory write |
| bus_addr | output | AW | Word address |
| bus_wdata | output | DW | Memory write data |
| bus_rdata | input | DW | Memory read data, same cycle |
| bus_err | input | 1 | Error response for the current cycle |
| per_req | input | 1 | Peripheral data request |
| per_ack | output | 1 | One peripheral word moved |
| per_wdata | output | DW | Word delivered to peripheral |
| per_rdata | input | DW | Word offered by peripheral |
| busy | output | 1 | A job is active |
| done | output | 1 | Sticky completion flag |
| err | output | 1 | Sticky fault flag |
| busy_err | output | 1 | Sticky refused-start flag |
| irq | output | 1 | Sticky interrupt request |

## Verification
The completion flag can be set by the final word in the same cycle as software's write-1-to-clear of that flag. The bench provokes this by scheduling the clear write for the exact cycle of the last word of a two-word burst. It then requires done and irq to read 1 afterwards. A cycle-by-cycle behavioural model also runs alongside the block and checks, every clock, the request line, the beat strobe, the address and the flags in every policy. This includes the cycles where the grant is withdrawn and the cycles where a start arrives while a job is still running.

// File: rtl/dma_ctl_pkg.sv
package dma_ctl_pkg;
   typedef enum logic [1:0] {
      MODE_BURST  = 2'd0,
      MODE_STEAL  = 2'd1,
      MODE_BLOCK  = 2'd2,
      MODE_DEMAND = 2'd3
   } xfer_mode_e;

   typedef enum logic [1:0] {
      ST_IDLE = 2'd0,
      ST_PARK = 2'd1,
      ST_OWN  = 2'd2
   } own_state_e;

   // direction codes; bit 1 set selects memory-to-memory
   localparam logic [1:0] DIR_TO_PER   = 2'd0;
   localparam logic [1:0] DIR_FROM_PER = 2'd1;

   localparam logic [2:0] SEL_SRC  = 3'd0;
   localparam logic [2:0] SEL_DST  = 3'd1;
   localparam logic [2:0] SEL_CNT  = 3'd2;
   localparam logic [2:0] SEL_CTRL = 3'd3;
   localparam logic [2:0] SEL_CMD  = 3'd4;
   localparam logic [2:0] SEL_CLR  = 3'd5;
endpackage

// File: rtl/dma_ctl_regs.sv
module dma_ctl_regs
   import dma_ctl_pkg::*;
#(
   parameter int AW = 16,
   parameter int CW = 16,
   parameter int RW = 16
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [2:0]    reg_sel,
   input  logic [RW-1:0] reg_wdata,
   input  logic          idle,
   input  logic          inc_src,
   input  logic          inc_dst,
   input  logic          dec_cnt,
   input  logic          set_done,
   input  logic          set_err,
   input  logic          set_busy_err,
   input  logic          set_irq,
   output logic [AW-1:0] src,
   output logic [AW-1:0] dst,
   output logic [CW-1:0] cnt,
   output logic [1:0]    dir,
   output xfer_mode_e    mode,
   output logic          ie,
   output logic          start_cmd,
   output logic          done,
   output logic          err,
   output logic          busy_err,
   output logic          irq
);
   localparam logic [AW-1:0] A_ONE = 1;
   localparam logic [CW-1:0] C_ONE = 1;

   logic cfg_wr, clr_wr;
   assign cfg_wr    = reg_we && idle;
   assign clr_wr    = reg_we && (reg_sel == SEL_CLR);
   assign start_cmd = reg_we && (reg_sel == SEL_CMD) && reg_wdata[0];

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         src <= '0; dst <= '0; cnt <= '0;
         dir <= DIR_TO_PER; mode <= MODE_BURST; ie <= 1'b0;
         done <= 1'b0; err <= 1'b0; busy_err <= 1'b0; irq <= 1'b0;
      end else begin
         if (cfg_wr && reg_sel == SEL_SRC) src <= reg_wdata[AW-1:0];
         else if (inc_src)                 src <= src + A_ONE;
         if (cfg_wr && reg_sel == SEL_DST) dst <= reg_wdata[AW-1:0];
         else if (inc_dst)                 dst <= dst + A_ONE;
         if (cfg_wr && reg_sel == SEL_CNT) cnt <= reg_wdata[CW-1:0];
         else if (dec_cnt)                 cnt <= cnt - C_ONE;
         if (cfg_wr && reg_sel == SEL_CTRL) begin
            dir  <= reg_wdata[1:0];
            mode <= xfer_mode_e'(reg_wdata[3:2]);
            ie   <= reg_wdata[4];
         end
         // set has priority over a simultaneous clear
         done     <= set_done     | (done     & ~(clr_wr & reg_wdata[0]));
         err      <= set_err      | (err      & ~(clr_wr & reg_wdata[1]));
         busy_err <= set_busy_err | (busy_err & ~(clr_wr & reg_wdata[2]));
         irq      <= set_irq      | (irq      & ~(clr_wr & reg_wdata[3]));
      end
   end
endmodule

// File: rtl/dma_ctl_guard.sv
module dma_ctl_guard #(
   parameter int            AW    = 16,
   parameter logic [AW-1:0] LIMIT = '1,
   parameter bit            EN    = 1'b1
) (
   input  logic [AW-1:0] addr,
   output logic          bad
);
   generate
      if (EN) begin : g_cmp
         assign bad = (addr > LIMIT);
      end else begin : g_off
         assign bad = 1'b0;
      end
   endgenerate
endmodule

// File: rtl/dma_ctl_fsm.sv
module dma_ctl_fsm
   import dma_ctl_pkg::*;
#(
   parameter int CW      = 16,
   parameter int DW      = 32,
   parameter int BLK_LEN = 4
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_cmd,
   input  logic [CW-1:0] cnt,
   input  logic [1:0]    dir,
   input  xfer_mode_e    mode,
   input  logic          ie,
   input  logic          bus_gnt,
   input  logic          per_req,
   input  logic          bus_err,
   input  logic          addr_bad,
   input  logic [DW-1:0] bus_rdata,
   output logic          bus_req,
   output logic          bus_valid,
   output logic          wr_phase,
   output logic [DW-1:0] hold,
   output logic          inc_src,
   output logic          inc_dst,
   output logic          dec_cnt,
   output logic          set_done,
   output logic          set_err,
   output logic          set_busy_err,
   output logic          set_irq,
   output logic          idle,
   output logic          per_ack
);
   localparam int            BW       = (BLK_LEN > 1) ? $clog2(BLK_LEN) : 1;
   localparam logic [BW-1:0] BLK_LAST = BW'(BLK_LEN - 1);
   localparam logic [BW-1:0] BLK_ONE  = 1;
   localparam logic [CW-1:0] CNT_ONE  = 1;

   own_state_e    state, state_nx;
   logic [BW-1:0] blk;
   logic          phase, mem_copy, demand, active, fault, beat;
   logic          word_done, last_word, start_ok, zero_start;

   assign mem_copy   = dir[1];
   assign demand     = (mode == MODE_DEMAND);
   assign wr_phase   = (dir == DIR_FROM_PER) || (mem_copy && phase);
   assign idle       = (state == ST_IDLE);
   assign bus_req    = (state == ST_OWN);
   assign active     = bus_req && bus_gnt && (!demand || per_req);
   assign bus_valid  = active && !addr_bad;
   assign fault      = active && (addr_bad || bus_err);
   assign beat       = bus_valid && !bus_err;
   assign word_done  = beat && (!mem_copy || phase);
   assign last_word  = word_done && (cnt == CNT_ONE);
   assign start_ok   = start_cmd && idle;
   assign zero_start = start_ok && (cnt == '0);

   assign inc_src      = beat && !wr_phase;
   assign inc_dst      = beat && wr_phase;
   assign dec_cnt      = word_done;
   assign per_ack      = beat && !mem_copy;
   assign set_done     = last_word || zero_start;
   assign set_err      = fault;
   assign set_busy_err = start_cmd && !idle;
   assign set_irq      = ie && (set_done || fault);

   always_comb begin
      state_nx = state;
      case (state)
         ST_IDLE: if (start_ok && !zero_start) state_nx = demand ? ST_PARK : ST_OWN;
         ST_PARK: if (!demand || per_req) state_nx = ST_OWN;
         ST_OWN: begin
            if (fault || last_word) state_nx = ST_IDLE;
            else if (word_done) begin
               if (mode == MODE_STEAL || (mode == MODE_BLOCK && blk == BLK_LAST))
                  state_nx = ST_PARK;
            end else if (demand && !per_req) state_nx = ST_PARK;
         end
         default: state_nx = ST_IDLE;
      endcase
   end

   always_ff @(posedge clk) begin
      if (!rst_n) begin
         state <= ST_IDLE;
         blk   <= '0;
         phase <= 1'b0;
         hold  <= '0;
      end else begin
         state <= state_nx;
         if (state_nx != ST_OWN) blk <= '0;
         else if (word_done)     blk <= blk + BLK_ONE;
         if (state_nx == ST_IDLE)     phase <= 1'b0;
         else if (beat && mem_copy)   phase <= ~phase;
         if (beat && mem_copy && !phase) hold <= bus_rdata;
      end
   end
endmodule

// File: rtl/dma_ctl.sv
module dma_ctl
   import dma_ctl_pkg::*;
#(
   parameter int            AW         = 16,
   parameter int            CW         = 16,
   parameter int            DW         = 32,
   parameter int            BLK_LEN    = 4,
   parameter logic [AW-1:0] ADDR_LIMIT = AW'(255),
   parameter bit            LIMIT_EN   = 1'b1,
   localparam int           RW         = (AW > CW) ? AW : CW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          reg_we,
   input  logic [2:0]    reg_sel,
   input  logic [RW-1:0] reg_wdata,
   output logic          bus_req,
   input  logic          bus_gnt,
   output logic          bus_valid,
   output logic          bus_we,
   output logic [AW-1:0] bus_addr,
   output logic [DW-1:0] bus_wdata,
   input  logic [DW-1:0] bus_rdata,
   input  logic          bus_err,
   input  logic          per_req,
   output logic          per_ack,
   output logic [DW-1:0] per_wdata,
   input  logic [DW-1:0] per_rdata,
   output logic          busy,
   output logic          done,
   output logic          err,
   output logic          busy_err,
   output logic          irq
);
   generate
      if (RW < 5)      begin : g_bad_rw  $error("register width must hold the control word"); end
      if (BLK_LEN < 1) begin : g_bad_blk $error("BLK_LEN must be at least 1"); end
      if (CW < 1)      begin : g_bad_cw  $error("CW must be at least 1"); end
   endgenerate

   logic [AW-1:0] src, dst;
   logic [CW-1:0] cnt;
   logic [1:0]    cfg_dir;
   xfer_mode_e    cfg_mode;
   logic          cfg_ie, start_cmd, idle, wr_phase, addr_bad;
   logic          inc_src, inc_dst, cnt_dec;
   logic          set_done, set_err, set_busy_err, set_irq;
   logic [DW-1:0] hold;

   dma_ctl_regs #(.AW(AW), .CW(CW), .RW(RW)) regs_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .idle(idle), .inc_src(inc_src), .inc_dst(inc_dst), .dec_cnt(cnt_dec),
      .set_done(set_done), .set_err(set_err), .set_busy_err(set_busy_err), .set_irq(set_irq),
      .src(src), .dst(dst), .cnt(cnt), .dir(cfg_dir), .mode(cfg_mode), .ie(cfg_ie),
      .start_cmd(start_cmd), .done(done), .err(err), .busy_err(busy_err), .irq(irq)
   );

   dma_ctl_guard #(.AW(AW), .LIMIT(ADDR_LIMIT), .EN(LIMIT_EN)) guard_i (
      .addr(bus_addr), .bad(addr_bad)
   );

   dma_ctl_fsm #(.CW(CW), .DW(DW), .BLK_LEN(BLK_LEN)) fsm_i (
      .clk(clk), .rst_n(rst_n), .start_cmd(start_cmd), .cnt(cnt), .dir(cfg_dir),
      .mode(cfg_mode), .ie(cfg_ie), .bus_gnt(bus_gnt), .per_req(per_req),
      .bus_err(bus_err), .addr_bad(addr_bad), .bus_rdata(bus_rdata),
      .bus_req(bus_req), .bus_valid(bus_valid), .wr_phase(wr_phase), .hold(hold),
      .inc_src(inc_src), .inc_dst(inc_dst), .dec_cnt(cnt_dec), .set_done(set_done),
      .set_err(set_err), .set_busy_err(set_busy_err), .set_irq(set_irq),
      .idle(idle), .per_ack(per_ack)
   );

   assign bus_addr  = wr_phase ? dst : src;
   assign bus_we    = wr_phase;
   assign bus_wdata = (cfg_dir == DIR_FROM_PER) ? per_rdata : hold;
   assign per_wdata = bus_rdata;
   assign busy      = !idle;
endmodule

// File: rtl/dma_ctl_chk.sv
module dma_ctl_chk
   import dma_ctl_pkg::*;
#(
   parameter int AW = 16
) (
   input logic          clk,
   input logic          rst_n,
   input logic          bus_req,
   input logic          bus_gnt,
   input logic          bus_valid,
   input logic [AW-1:0] bus_addr,
   input logic          per_req,
   input logic          irq,
   input logic          err,
   input logic          cfg_ie,
   input logic          cnt_dec,
   input xfer_mode_e    cfg_mode
);
   a_r2_valid_needs_grant: assert property (@(posedge clk) disable iff (!rst_n)
      bus_valid |-> (bus_req && bus_gnt));

   a_r6_demand_gated: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_valid && cfg_mode == MODE_DEMAND) |-> per_req);

   a_r4_steal_release: assert property (@(posedge clk) disable iff (!rst_n)
      (cnt_dec && cfg_mode == MODE_STEAL) |=> !bus_req);

   a_r11_pause_holds: assert property (@(posedge clk) disable iff (!rst_n)
      (bus_req && !bus_gnt && cfg_mode != MODE_DEMAND) |=> (bus_req && $stable(bus_addr)));

   a_r7_irq_needs_ie: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(irq) |-> cfg_ie);

   a_r8_err_releases: assert property (@(posedge clk) disable iff (!rst_n)
      $rose(err) |-> !bus_req);
endmodule

bind dma_ctl dma_ctl_chk #(.AW(AW)) chk_i (.*);

// File: tb/dma_ctl_tb_top.sv
module dma_ctl_tb_top;
   localparam int          CLK_PERIOD = 10;
   localparam int          BLK        = 4;
   localparam logic [15:0] LIMIT      = 16'h00FF;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_we = 1'b0;
   logic [2:0]  reg_sel = '0;
   logic [15:0] reg_wdata = '0;
   logic        bus_req, bus_valid, bus_we, per_ack, busy, done, err, busy_err, irq;
   logic        bus_gnt = 1'b0, bus_err = 1'b0, per_req = 1'b0;
   logic [15:0] bus_addr;
   logic [31:0] bus_wdata, bus_rdata, per_wdata;
   logic [31:0] per_rdata = 32'hC0DE_0000;

   logic [31:0] mem [0:255];
   assign bus_rdata = mem[bus_addr[7:0]];

   always #(CLK_PERIOD/2) clk = ~clk;

   dma_ctl #(.AW(16), .CW(16), .DW(32), .BLK_LEN(BLK), .ADDR_LIMIT(LIMIT)) dut_i (
      .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_sel(reg_sel), .reg_wdata(reg_wdata),
      .bus_req(bus_req), .bus_gnt(bus_gnt), .bus_valid(bus_valid), .bus_we(bus_we),
      .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .bus_err(bus_err),
      .per_req(per_req), .per_ack(per_ack), .per_wdata(per_wdata), .per_rdata(per_rdata),
      .busy(busy), .done(done), .err(err), .busy_err(busy_err), .irq(irq)
   );

   int tests = 0, fails = 0;
   int cyc = 0, rises = 0;
   int gnt_off_lo = -1, gnt_off_hi = -1, err_cyc = -1;
   bit demand_pat = 0, prev_req = 0;
   logic [31:0] rxq [$];
   bit pend_wr = 0, pend_inc = 0;
   logic [7:0] pend_a;
   logic [31:0] pend_d;

   // behavioural reference state
   int m_state = 0, m_phase = 0, m_blk = 0, m_src = 0, m_dst = 0, m_cnt = 0;
   int m_dir = 0, m_mode = 0, m_ie = 0;
   bit m_done = 0, m_err = 0, m_berr = 0, m_irq = 0;
   bit mc_req, mc_valid, mc_we, mc_ack, mc_fault, mc_ok, mc_word;
   int mc_addr;
   bit s_we, s_gnt, s_preq, s_berr;
   int s_sel, s_wd;

   task automatic chk(string tag, string what, logic [31:0] act, logic [31:0] exp);
      tests++;
      if (act !== exp) begin
         fails++;
         $display("FAIL %s %s: got %0h expected %0h (cycle %0d)", tag, what, act, exp, cyc);
      end
   endtask

   task automatic model_comb();
      bit m2m, act, bad;
      m2m      = (m_dir >= 2);
      mc_we    = (m_dir == 1) || (m2m && m_phase == 1);
      mc_addr  = mc_we ? m_dst : m_src;
      bad      = mc_addr > int'(LIMIT);
      mc_req   = (m_state == 2);
      act      = mc_req && s_gnt && (m_mode != 3 || s_preq);
      mc_valid = act && !bad;
      mc_fault = act && (bad || s_berr);
      mc_ok    = mc_valid && !s_berr;
      mc_word  = mc_ok && (!m2m || m_phase == 1);
      mc_ack   = mc_ok && !m2m;
   endtask

   task automatic model_edge();
      bit cmd, start_ok, set_d, m2m, last;
      int cnt_before;
      m2m        = (m_dir >= 2);
      cmd        = s_we && s_sel == 4 && s_wd[0];
      start_ok   = cmd && m_state == 0;
      cnt_before = m_cnt;
      last       = mc_word && cnt_before == 1;
      set_d      = last || (start_ok && cnt_before == 0);
      if (s_we && s_sel == 5) begin
         if (s_wd[0]) m_done = 0;
         if (s_wd[1]) m_err  = 0;
         if (s_wd[2]) m_berr = 0;
         if (s_wd[3]) m_irq  = 0;
      end
      if (set_d) m_done = 1;
      if (mc_fault) m_err = 1;
      if (cmd && m_state != 0) m_berr = 1;
      if (m_ie != 0 && (set_d || mc_fault)) m_irq = 1;
      if (mc_ok && !mc_we) m_src = (m_src + 1) & 16'hFFFF;
      if (mc_ok && mc_we)  m_dst = (m_dst + 1) & 16'hFFFF;
      if (mc_word) m_cnt = (m_cnt - 1) & 16'hFFFF;
      if (mc_ok && m2m) m_phase = (m_phase == 0) ? 1 : 0;
      case (m_state)
         0: if (start_ok && cnt_before != 0) m_state = (m_mode == 3) ? 1 : 2;
         1: if (m_mode != 3 || s_preq) m_state = 2;
         default: begin
            if (mc_fault || last) begin m_state = 0; m_phase = 0; m_blk = 0; end
            else if (mc_word) begin
               if (m_mode == 1) m_state = 1;
               else if (m_mode == 2) begin
                  if (m_blk == BLK - 1) begin m_blk = 0; m_state = 1; end
                  else m_blk++;
               end
            end else if (m_mode == 3 && !s_preq) m_state = 1;
         end
      endcase
      if (m_state == 0 && s_we) begin
         case (s_sel)
            0: m_src = s_wd;
            1: m_dst = s_wd;
            2: m_cnt = s_wd;
            3: begin m_dir = s_wd & 3; m_mode = (s_wd >> 2) & 3; m_ie = (s_wd >> 4) & 1; end
            default: ;
         endcase
      end
   endtask

   task automatic cycle(bit we = 0, logic [2:0] sel = 3'd0, logic [15:0] wd = 16'd0);
      logic v, w, ack;
      @(negedge clk);
      if (pend_wr) mem[pend_a] = pend_d;
      if (pend_inc) per_rdata = per_rdata + 32'd1;
      pend_wr = 0; pend_inc = 0;
      reg_we = we; reg_sel = sel; reg_wdata = wd;
      bus_gnt = bus_req && !(cyc >= gnt_off_lo && cyc < gnt_off_hi);
      per_req = demand_pat ? ((cyc % 3) != 2) : 1'b1;
      bus_err = (cyc == err_cyc);
      s_we = we; s_sel = int'(sel); s_wd = int'(wd);
      s_gnt = bus_gnt; s_preq = per_req; s_berr = bus_err;
      #1;
      model_comb();
      chk("R2", "bus_req", bus_req, mc_req);
      chk("R2", "bus_valid", bus_valid, mc_valid);
      if (mc_valid) begin
         chk("R9", "bus_addr", bus_addr, mc_addr);
         chk("R9", "bus_we", bus_we, mc_we);
      end
      chk("R9", "per_ack", per_ack, mc_ack);
      chk("R7", "busy", busy, m_state != 0);
      chk("R7", "done", done, m_done);
      chk("R8", "err", err, m_err);
      chk("R10", "busy_err", busy_err, m_berr);
      chk("R13", "irq", irq, m_irq);
      if (bus_req && !prev_req) rises++;
      prev_req = bus_req;
      v = bus_valid; w = bus_we; ack = per_ack;
      if (v && w && !bus_err) begin pend_wr = 1; pend_a = bus_addr[7:0]; pend_d = bus_wdata; end
      if (ack && !w) rxq.push_back(per_wdata);
      if (ack && w) pend_inc = 1;
      @(posedge clk);
      model_edge();
      cyc++;
   endtask

   task automatic wait_idle();
      for (int k = 0; k < 200 && (busy || m_state != 0); k++) cycle();
      cycle();
   endtask

   task automatic setup(int src, int dst, int cnt, int dir, int mode, int ie);
      cycle(1, 3'd5, 16'h000F);
      cycle(1, 3'd0, 16'(src));
      cycle(1, 3'd1, 16'(dst));
      cycle(1, 3'd2, 16'(cnt));
      cycle(1, 3'd3, 16'(dir | (mode << 2) | (ie << 4)));
      rxq.delete();
      rises = 0;
   endtask

   task automatic run(int src, int dst, int cnt, int dir, int mode, int ie);
      setup(src, dst, cnt, dir, mode, ie);
      cycle(1, 3'd4, 16'h0001);
      wait_idle();
   endtask

   task automatic chk_rx(string tag, int base, int n);
      chk(tag, "rx word count", rxq.size(), n);
      for (int i = 0; i < n && i < rxq.size(); i++)
         chk(tag, "rx word", rxq[i], mem[base + i]);
   endtask

   initial begin
      #(CLK_PERIOD * 150000);
      fails++;
      $display("FAIL R2 watchdog: got hang expected completion");
      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end

   initial begin
      logic [31:0] p0, keep;
      for (int i = 0; i < 256; i++) mem[i] = 32'h5A00_0000 | (i * 32'h0101);
      repeat (3) @(posedge clk);
      #1 rst_n = 1'b1;
      // reset state
      cycle();
      chk("R1", "reset busy", busy, 0);
      chk("R13", "reset flags", {done, err, busy_err, irq}, 0);

      // R3 burst, memory to peripheral, interrupt on
      run(16'h10, 0, 5, 0, 0, 1);
      chk("R3", "burst request edges", rises, 1);
      chk_rx("R9", 16'h10, 5);
      chk("R7", "burst done/irq", {done, irq}, 2'b11);

      // R4 cycle-steal, peripheral to memory, interrupt off
      p0 = per_rdata;
      run(0, 16'h40, 4, 1, 1, 0);
      chk("R4", "steal request edges", rises, 4);
      for (int i = 0; i < 4; i++) chk("R9", "p2m word", mem[16'h40 + i], p0 + 32'(i));
      chk("R7", "no irq when disabled", {done, irq}, 2'b10);

      // R5 block, memory to memory
      run(16'h20, 16'h60, 6, 2, 2, 1);
      chk("R5", "block request edges", rises, 2);
      for (int i = 0; i < 6; i++) chk("R9", "m2m word", mem[16'h60 + i], mem[16'h20 + i]);

      // R6 demand with a toggling peripheral request
      demand_pat = 1;
      run(16'h30, 0, 5, 0, 3, 0);
      demand_pat = 0;
      chk_rx("R6", 16'h30, 5);
      chk("R6", "demand done", done, 1);

      // R11 grant withdrawn mid burst
      setup(16'h50, 0, 6, 0, 0, 0);
      gnt_off_lo = cyc + 3; gnt_off_hi = cyc + 7;
      cycle(1, 3'd4, 16'h0001);
      wait_idle();
      gnt_off_lo = -1; gnt_off_hi = -1;
      chk("R11", "single ownership across pause", rises, 1);
      chk_rx("R11", 16'h50, 6);

      // R12 zero count
      setup(0, 0, 0, 0, 0, 1);
      cycle(1, 3'd4, 16'h0001);
      cycle();
      chk("R12", "zero count done/irq", {done, irq}, 2'b11);
      chk("R12", "zero count no request", rises, 0);

      // R10 start while busy, R1 config write while busy
      setup(16'h18, 0, 3, 0, 1, 0);
      cycle(1, 3'd4, 16'h0001);
      cycle(1, 3'd0, 16'h0099);
      cycle(1, 3'd4, 16'h0001);
      wait_idle();
      chk("R10", "busy error flag", busy_err, 1);
      chk_rx("R1", 16'h18, 3);

      // R8 address above ceiling
      run(16'hFE, 0, 4, 0, 0, 1);
      chk_rx("R8", 16'hFE, 2);
      chk("R8", "limit fault flags", {done, err, irq}, 3'b011);

      // R8 bus error response
      keep = mem[16'h84];
      setup(0, 16'h80, 5, 1, 0, 0);
      cycle(1, 3'd4, 16'h0001);
      err_cyc = cyc + 2;
      wait_idle();
      err_cyc = -1;
      chk("R8", "bus error flag", {done, err}, 2'b01);
      chk("R8", "no write after fault", mem[16'h84], keep);

      // R13 clear colliding with completion: set wins
      setup(16'h08, 0, 2, 0, 0, 1);
      cycle(1, 3'd4, 16'h0001);
      cycle();
      cycle(1, 3'd5, 16'h000F);
      cycle();
      chk("R13", "set beats clear", {done, irq}, 2'b11);
      cycle(1, 3'd5, 16'h0009);
      cycle();
      chk("R13", "write-1 clear", {done, irq}, 2'b00);

      $display("[TB] %0d tests run, %0d failed", tests, fails);
      $finish;
   end
endmodule